// File: doc/BRIEF.md
# Paged 32-bit Register Window over Management Accesses

This block sits behind a clause-22 style management frame decoder and opens a 32-bit internal register space to a 16-bit management master. Each decoded transaction arrives as one strobe carrying a PHY address, a register number, a read/write flag and 16 bits of write data. A page register supplies the high part of a 32-bit word index. The other index bits come from the PHY address, which must fall in the window 0x10 to 0x17, and from the register number. The even register of a pair carries word bits [15:0] and the odd register carries bits [31:16]. The word index equals a byte address with its two low bits dropped.

Software writes a word as upper half first, then lower half, and reads it as lower half first, then upper half. The bridge follows that order so that every internal access is a whole 32-bit one. An upper-half write only goes into a staging register, and the lower-half write then issues one 32-bit bus write. A lower-half read fetches the whole word and keeps its upper half. The upper-half read that follows returns that kept value, so the pair of reads comes from one bus read.

Control is one state machine with the states IDLE, WRITE, READ, CAPTURE and DONE. IDLE accepts a transaction. It goes to WRITE for a lower-half write and to READ for a lower-half read, and goes straight to DONE for anything else. WRITE moves to DONE. READ moves to CAPTURE while the bus slave registers its read data. CAPTURE stores the data and moves to DONE. DONE pulses the completion flag and returns to IDLE.

Top module: `mdio_page_bridge`

## Requirements
- R1: After reset the page register, the write staging register and the read latch are all zero, `mgmt_ready` is 1, and `bus_wr`, `bus_rd` and `mgmt_done` are 0.
- R2: A write to PHY address 0x1F, register 0x10, loads the page register from write-data bits [8:0]. A read of the same address returns the page value zero-extended to 16 bits.
- R3: For PHY addresses 0x10 to 0x17 the bus word index is {page[8:0], PHY address bits [2:0], register number bits [4:1]}. Register-number bit 0 selects the half: 0 is bits [15:0], 1 is bits [31:16].
- R4: An upper-half (odd register) write in the window stores its data in the staging register and causes no bus strobe. Completion is signalled one cycle after acceptance.
- R5: A lower-half (even register) write in the window drives `bus_wr` for exactly one cycle, with data {staging register, write data}. `mgmt_done` follows in the next cycle, two cycles after acceptance.
- R6: The staging register keeps its value after a bus write, so a later lower-half write with no upper-half write reuses the previous upper half. Straight after reset that upper half is 0x0000.
- R7: A lower-half read in the window drives `bus_rd` for one cycle. It returns `bus_rdata[15:0]`, which the slave presents in the cycle after the strobe, and latches `bus_rdata[31:16]`. `mgmt_done` comes three cycles after acceptance.
- R8: An upper-half read in the window returns the value latched by the last lower-half read, even if the word has changed since then, and causes no bus strobe.
- R9: A transaction to any other PHY address, or to PHY 0x1F at a register other than 0x10, causes no bus strobe and changes neither the page nor the staging register. A read of such an address returns 0xFFFF.
- R10: `mgmt_done` is a one-cycle pulse with `mgmt_rdata` valid in the same cycle, and `mgmt_ready` is 1 again in the cycle after it. A `mgmt_valid` raised while `mgmt_ready` is 0 is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mgmt_valid | input | 1 | Transaction strobe from the frame decoder |
| mgmt_ready | output | 1 | Bridge is idle and accepts a strobe |
| mgmt_phy | input | 5 | PHY address of the transaction |
| mgmt_reg | input | 5 | Register number of the transaction |
| mgmt_write | input | 1 | 1 for a write, 0 for a read |
| mgmt_wdata | input | 16 | Write data |
| mgmt_done | output | 1 | Transaction completed (one-cycle pulse) |
| mgmt_rdata | output | 16 | Read data, valid while `mgmt_done` is 1 |
| bus_addr | output | 16 | Word index of the internal access |
| bus_wdata | output | 32 | Internal write data |
| bus_wr | output | 1 | Internal write strobe |
| bus_rd | output | 1 | Internal read strobe |
| bus_rdata | input | 32 | Internal read data, valid one cycle after `bus_rd` |

## Verification
The case that is hardest to reach from the ports is the consistency of a split read: the word must change between the lower-half read and the upper-half read, and the upper half must still come back as it was before the change. The bench plays the register file itself. After the lower-half read completes, it overwrites the word in its own model, then reads the upper half and expects the old value. A second case needs the staging register to survive foreign traffic. An upper-half write goes to an address outside the window, and the next in-window lower-half write must still carry the earlier upper half. A strobe raised while a read is in flight must leave the page unchanged.

// File: rtl/mpb_pkg.sv
package mpb_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WRITE,
        ST_READ,
        ST_CAPTURE,
        ST_DONE
    } mpb_state_e;

    typedef enum logic [2:0] {
        AK_PAGE_WR,
        AK_PAGE_RD,
        AK_HALF_LO,
        AK_HALF_HI,
        AK_IGNORE
    } mpb_kind_e;

    localparam logic [4:0]  PAGE_PHY  = 5'h1F;
    localparam logic [4:0]  PAGE_REG  = 5'h10;
    localparam logic [4:0]  WIN_BASE  = 5'h10;
    localparam logic [15:0] MISS_DATA = 16'hFFFF;

endpackage

// File: rtl/mpb_hold_reg.sv
module mpb_hold_reg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] din,
    output logic [W-1:0] q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load) begin
            q <= din;
        end
    end

endmodule

// File: rtl/mpb_decode.sv
module mpb_decode
    import mpb_pkg::*;
#(
    parameter int PAGE_W = 9,
    parameter int ROW_W  = 3,
    parameter int COL_W  = 4,
    localparam int IDX_W = PAGE_W + ROW_W + COL_W
) (
    input  logic [4:0]        phy,
    input  logic [4:0]        regn,
    input  logic              is_write,
    input  logic [PAGE_W-1:0] page,
    output mpb_kind_e         kind,
    output logic [IDX_W-1:0]  word_idx
);

    localparam logic [4:0] WIN_TOP = WIN_BASE >> ROW_W;

    logic in_window;
    logic is_page;

    always_comb begin
        in_window = ((phy >> ROW_W) == WIN_TOP);
        is_page   = (phy == PAGE_PHY) && (regn == PAGE_REG);
        word_idx  = {page, phy[ROW_W-1:0], regn[COL_W:1]};

        if (is_page) begin
            kind = is_write ? AK_PAGE_WR : AK_PAGE_RD;
        end else if (in_window) begin
            kind = regn[0] ? AK_HALF_HI : AK_HALF_LO;
        end else begin
            kind = AK_IGNORE;
        end
    end

endmodule

// File: rtl/mdio_page_bridge.sv
module mdio_page_bridge
    import mpb_pkg::*;
#(
    parameter int PAGE_W = 9,
    parameter int ROW_W  = 3,
    parameter int COL_W  = 4,
    parameter int HALF_W = 16,
    localparam int IDX_W  = PAGE_W + ROW_W + COL_W,
    localparam int WORD_W = 2 * HALF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mgmt_valid,
    output logic              mgmt_ready,
    input  logic [4:0]        mgmt_phy,
    input  logic [4:0]        mgmt_reg,
    input  logic              mgmt_write,
    input  logic [HALF_W-1:0] mgmt_wdata,
    output logic              mgmt_done,
    output logic [HALF_W-1:0] mgmt_rdata,
    output logic [IDX_W-1:0]  bus_addr,
    output logic [WORD_W-1:0] bus_wdata,
    output logic              bus_wr,
    output logic              bus_rd,
    input  logic [WORD_W-1:0] bus_rdata
);

    mpb_state_e          state_q;
    mpb_state_e          state_d;
    mpb_kind_e           kind;
    logic [IDX_W-1:0]    word_idx;
    logic [PAGE_W-1:0]   page_q;
    logic [HALF_W-1:0]   wr_hi_q;
    logic [HALF_W-1:0]   rd_hi_q;
    logic                accept;
    logic [IDX_W-1:0]    addr_q;
    logic [WORD_W-1:0]   wdata_q;
    logic [HALF_W-1:0]   rdata_q;

    assign accept = mgmt_valid && (state_q == ST_IDLE);

    // ---------------- address decode ----------------
    mpb_decode #(
        .PAGE_W (PAGE_W),
        .ROW_W  (ROW_W),
        .COL_W  (COL_W)
    ) i_decode (
        .phy      (mgmt_phy),
        .regn     (mgmt_reg),
        .is_write (mgmt_write),
        .page     (page_q),
        .kind     (kind),
        .word_idx (word_idx)
    );

    // ---------------- page, write staging, read latch ----------------
    mpb_hold_reg #(.W(PAGE_W)) i_page (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (accept && (kind == AK_PAGE_WR)),
        .din   (mgmt_wdata[PAGE_W-1:0]),
        .q     (page_q)
    );

    mpb_hold_reg #(.W(HALF_W)) i_wr_stage (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (accept && (kind == AK_HALF_HI) && mgmt_write),
        .din   (mgmt_wdata),
        .q     (wr_hi_q)
    );

    mpb_hold_reg #(.W(HALF_W)) i_rd_latch (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (state_q == ST_CAPTURE),
        .din   (bus_rdata[WORD_W-1:HALF_W]),
        .q     (rd_hi_q)
    );

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    if (kind == AK_HALF_LO) begin
                        state_d = mgmt_write ? ST_WRITE : ST_READ;
                    end else begin
                        state_d = ST_DONE;
                    end
                end
            end
            ST_WRITE:   state_d = ST_DONE;
            ST_READ:    state_d = ST_CAPTURE;
            ST_CAPTURE: state_d = ST_DONE;
            ST_DONE:    state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // ---------------- transaction data ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
        end else if (accept) begin
            addr_q  <= word_idx;
            wdata_q <= {wr_hi_q, mgmt_wdata};
            unique case (kind)
                AK_PAGE_RD: rdata_q <= {{(HALF_W-PAGE_W){1'b0}}, page_q};
                AK_HALF_HI: rdata_q <= mgmt_write ? rdata_q : rd_hi_q;
                AK_IGNORE:  rdata_q <= mgmt_write ? rdata_q : MISS_DATA;
                default:    rdata_q <= rdata_q;
            endcase
        end else if (state_q == ST_CAPTURE) begin
            rdata_q <= bus_rdata[HALF_W-1:0];
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        mgmt_ready = 1'b0;
        mgmt_done  = 1'b0;
        bus_wr     = 1'b0;
        bus_rd     = 1'b0;
        unique case (state_q)
            ST_IDLE:    mgmt_ready = 1'b1;
            ST_WRITE:   bus_wr     = 1'b1;
            ST_READ:    bus_rd     = 1'b1;
            ST_CAPTURE: ;
            ST_DONE:    mgmt_done  = 1'b1;
            default:    ;
        endcase
        bus_addr   = addr_q;
        bus_wdata  = wdata_q;
        mgmt_rdata = rdata_q;
    end

endmodule

// File: rtl/mpb_checker.sv
module mpb_checker (
    input logic clk,
    input logic rst_n,
    input logic mgmt_valid,
    input logic mgmt_ready,
    input logic mgmt_done,
    input logic bus_wr,
    input logic bus_rd
);

    // R10: at most one of the three strobes at a time
    p_strobe_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({bus_wr, bus_rd, mgmt_done}));

    p_write_then_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr |=> (mgmt_done && !bus_wr));

    p_read_then_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |-> ##2 mgmt_done);

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mgmt_done |=> (mgmt_ready && !mgmt_done));

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (mgmt_ready && !mgmt_valid) |=> (mgmt_ready && !bus_wr && !bus_rd));

endmodule

bind mdio_page_bridge mpb_checker i_mpb_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .mgmt_valid (mgmt_valid),
    .mgmt_ready (mgmt_ready),
    .mgmt_done  (mgmt_done),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd)
);

// File: tb/test_mdio_page_bridge.sv
`timescale 1ns/1ps
module test_mdio_page_bridge;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mgmt_valid = 1'b0;
    logic        mgmt_ready;
    logic [4:0]  mgmt_phy = '0;
    logic [4:0]  mgmt_reg = '0;
    logic        mgmt_write = 1'b0;
    logic [15:0] mgmt_wdata = '0;
    logic        mgmt_done;
    logic [15:0] mgmt_rdata;
    logic [15:0] bus_addr;
    logic [31:0] bus_wdata;
    logic        bus_wr;
    logic        bus_rd;
    logic [31:0] bus_rdata = '0;

    int checks = 0;
    int errors = 0;
    int wr_count = 0;
    int rd_count = 0;
    logic [15:0] last_addr = '0;
    logic [31:0] last_data = '0;
    logic [31:0] mem [0:255];

    always #4 clk = ~clk;

    mdio_page_bridge i_mdio_page_bridge (
        .clk(clk), .rst_n(rst_n),
        .mgmt_valid(mgmt_valid), .mgmt_ready(mgmt_ready),
        .mgmt_phy(mgmt_phy), .mgmt_reg(mgmt_reg),
        .mgmt_write(mgmt_write), .mgmt_wdata(mgmt_wdata),
        .mgmt_done(mgmt_done), .mgmt_rdata(mgmt_rdata),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata)
    );

    // register file model: registered read data
    always @(posedge clk) begin
        if (bus_wr) begin
            mem[bus_addr[7:0]] <= bus_wdata;
            wr_count  <= wr_count + 1;
            last_addr <= bus_addr;
            last_data <= bus_wdata;
        end
        if (bus_rd) begin
            bus_rdata <= mem[bus_addr[7:0]];
            rd_count  <= rd_count + 1;
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic xfer(input logic [4:0] p, input logic [4:0] r, input bit w,
                        input logic [15:0] d, output logic [15:0] rd, output int lat);
        @(negedge clk);
        mgmt_valid = 1'b1; mgmt_phy = p; mgmt_reg = r; mgmt_write = w; mgmt_wdata = d;
        @(negedge clk);
        mgmt_valid = 1'b0;
        lat = 1;
        while (!mgmt_done && lat < 50) begin
            @(negedge clk);
            lat++;
        end
        rd = mgmt_rdata;
        @(negedge clk);
        check(!mgmt_done && mgmt_ready, "R10 done pulse/ready", {30'd0, mgmt_done, mgmt_ready}, 32'h1);
    endtask

    task automatic t_reset;
        logic [15:0] rd; int lat; int wc;
        check(mgmt_ready && !bus_wr && !bus_rd && !mgmt_done, "R1 idle outputs",
              {28'd0, mgmt_ready, bus_wr, bus_rd, mgmt_done}, 32'h8);
        xfer(5'h1F, 5'h10, 1'b0, 16'h0, rd, lat);
        check(rd == 16'h0000, "R1 page zero", {16'd0, rd}, 32'h0);
        wc = wr_count;
        xfer(5'h10, 5'h00, 1'b1, 16'h4321, rd, lat);
        check(wr_count == wc + 1 && last_data == 32'h0000_4321, "R6 R1 staging zero", last_data, 32'h0000_4321);
    endtask

    task automatic t_page;
        logic [15:0] rd; int lat;
        xfer(5'h1F, 5'h10, 1'b1, 16'hFFA5, rd, lat);
        check(lat == 1, "R2 page write latency", lat, 1);
        xfer(5'h1F, 5'h10, 1'b0, 16'h0, rd, lat);
        check(rd == 16'h01A5, "R2 page readback", {16'd0, rd}, 32'h01A5);
    endtask

    task automatic t_split_write;
        logic [15:0] rd; int lat; int wc;
        wc = wr_count;
        xfer(5'h15, 5'h07, 1'b1, 16'h1234, rd, lat);
        check(wr_count == wc && lat == 1, "R4 upper half staged only", wr_count - wc, 0);
        xfer(5'h15, 5'h06, 1'b1, 16'h5678, rd, lat);
        check(wr_count == wc + 1, "R5 one bus write", wr_count - wc, 1);
        check(lat == 2, "R5 write latency", lat, 2);
        check(last_addr == {9'h1A5, 3'b101, 4'b0011}, "R3 word index", {16'd0, last_addr},
              {16'd0, 9'h1A5, 3'b101, 4'b0011});
        check(last_data == 32'h1234_5678, "R5 write data", last_data, 32'h1234_5678);
        xfer(5'h15, 5'h06, 1'b1, 16'h9ABC, rd, lat);
        check(last_data == 32'h1234_9ABC, "R6 staging reused", last_data, 32'h1234_9ABC);
    endtask

    task automatic t_split_read;
        logic [15:0] rd; int lat; int rc;
        xfer(5'h1F, 5'h10, 1'b1, 16'h0000, rd, lat);
        xfer(5'h11, 5'h03, 1'b1, 16'hCAFE, rd, lat);
        xfer(5'h11, 5'h02, 1'b1, 16'hBEEF, rd, lat);
        check(last_addr == 16'h0011, "R3 page zero index", {16'd0, last_addr}, 32'h11);
        rc = rd_count;
        xfer(5'h11, 5'h02, 1'b0, 16'h0, rd, lat);
        check(rd == 16'hBEEF && lat == 3, "R7 lower read", {rd, 16'(lat)}, {16'hBEEF, 16'd3});
        mem[8'h11] = 32'h0000_0000;
        xfer(5'h11, 5'h03, 1'b0, 16'h0, rd, lat);
        check(rd == 16'hCAFE, "R8 latched upper", {16'd0, rd}, 32'hCAFE);
        check(rd_count == rc + 1, "R8 no extra bus read", rd_count - rc, 1);
        xfer(5'h11, 5'h02, 1'b0, 16'h0, rd, lat);
        xfer(5'h11, 5'h03, 1'b0, 16'h0, rd, lat);
        check(rd == 16'h0000, "R8 new upper after refetch", {16'd0, rd}, 32'h0);
    endtask

    task automatic t_outside;
        logic [15:0] rd; int lat; int wc; int rc;
        wc = wr_count; rc = rd_count;
        xfer(5'h08, 5'h00, 1'b1, 16'h1111, rd, lat);
        xfer(5'h05, 5'h01, 1'b1, 16'hDEAD, rd, lat);
        xfer(5'h1F, 5'h11, 1'b1, 16'h0077, rd, lat);
        check(wr_count == wc, "R9 no bus write", wr_count - wc, 0);
        xfer(5'h18, 5'h02, 1'b0, 16'h0, rd, lat);
        check(rd == 16'hFFFF, "R9 miss read phy18", {16'd0, rd}, 32'hFFFF);
        xfer(5'h1F, 5'h11, 1'b0, 16'h0, rd, lat);
        check(rd == 16'hFFFF, "R9 miss read phy1F", {16'd0, rd}, 32'hFFFF);
        check(rd_count == rc, "R9 no bus read", rd_count - rc, 0);
        xfer(5'h1F, 5'h10, 1'b0, 16'h0, rd, lat);
        check(rd == 16'h0000, "R9 page untouched", {16'd0, rd}, 32'h0);
        xfer(5'h12, 5'h04, 1'b1, 16'h0101, rd, lat);
        check(last_data == 32'hCAFE_0101, "R9 staging untouched", last_data, 32'hCAFE_0101);
    endtask

    task automatic t_busy_drop;
        logic [15:0] rd; int lat;
        @(negedge clk);
        mgmt_valid = 1'b1; mgmt_phy = 5'h12; mgmt_reg = 5'h04; mgmt_write = 1'b0;
        @(negedge clk);
        check(!mgmt_ready, "R10 busy during read", {31'd0, mgmt_ready}, 0);
        mgmt_phy = 5'h1F; mgmt_reg = 5'h10; mgmt_write = 1'b1; mgmt_wdata = 16'h00AA;
        @(negedge clk);
        mgmt_valid = 1'b0;
        while (!mgmt_done) @(negedge clk);
        check(mgmt_rdata == 16'h0101, "R10 in-flight read data", {16'd0, mgmt_rdata}, 32'h0101);
        xfer(5'h1F, 5'h10, 1'b0, 16'h0, rd, lat);
        check(rd == 16'h0000, "R10 dropped strobe", {16'd0, rd}, 32'h0);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_page();
        t_split_write();
        t_split_read();
        t_outside();
        t_busy_drop();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R10 watchdog actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule